// File: doc/BRIEF.md
# Processor Run/Stop Controller

This block starts and halts a set of virtual processors (VPs) and reports which of them are running. Software reaches it through a small register bus. A write to the start register launches every VP whose bit is set and that is not already running. A write to the halt register stops every VP whose bit is set and that is running. A read of the status register returns the running vector. The three registers can be reached at two address windows: a cluster-wide one and a core-local one. Both windows behave the same.

For each VP the block drives three outputs. A one-cycle reset pulse goes out when the VP is started. A run enable is high while the VP is running. A halt request is a level that stays high from a stop until the next start. Coming out of reset, every VP is halted. The VPs chosen by the `START_RUNNING` parameter are then launched through the same start sequence that software uses. A `START_RUNNING` value with a bit set at or above `NUM_VP` is a configuration error and stops elaboration.

The bus has no back-pressure. The block accepts a request in every cycle that `bus_valid` is high. A read answers exactly one cycle later with `rsp_valid`, and there is no ready signal because the block never stalls.

Top module: `vpc_runstop_ctrl`

## Requirements
- R1: Write-data bits at positions `NUM_VP` and above are ignored on start and halt writes. Status reads return zero in those bit positions.
- R2: A start write launches VP i only for a bit i that is 1 and whose VP is neither running nor already in its reset pulse. A VP that is running receives no new reset pulse. No reset pulse lasts longer than one cycle.
- R3: A start is seen in this order:
  - In the cycle after the write, `vp_reset_pulse[i]` is high for one cycle and `vp_halt_req[i]` drops.
  - `vp_run_en[i]` rises one cycle after that.
  - `vp_run_en[i]` is never high together with `vp_reset_pulse[i]`.
- R4: A halt write with bit i set stops VP i only if it is running. In the cycle after the write, `vp_run_en[i]` falls and `vp_halt_req[i]` rises. The halt request stays high until VP i is started again. Halting a VP that is not running changes nothing.
- R5: A read is answered in the next cycle with `rsp_valid` high. Writes produce no response.
- R6: The register offsets within each window are:
  - start at 0x10
  - halt at 0x18
  - status at 0x20
  A read of status returns the running vector zero-extended to 64 bits. A read at any other address returns zero. A write at any other address has no effect.
- R7: The cluster window (base 0x2000) and the core-local window (base 0x4000) decode the same three registers with identical behaviour.
- R8: While reset is held:
  - all run enables are 0
  - all reset pulses are 0
  - all halt requests are 1
  In the first cycle after reset is released, the VPs selected by `START_RUNNING` get their reset pulse. They show as running one cycle later.
- R9: A halt write that hits a VP during its reset pulse cancels the start. That VP never shows as running, and its halt request is set.
- R10: For each VP, the run enable is never high in the same cycle as that VP's halt request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Request present this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the request |
| bus_wdata | input | DATA_W | Write data, one bit per VP |
| rsp_valid | output | 1 | Read response valid, one cycle after the read |
| rsp_rdata | output | DATA_W | Read response data |
| vp_reset_pulse | output | NUM_VP | One-cycle reset pulse to each VP on start |
| vp_run_en | output | NUM_VP | Run enable per VP, equal to its running bit |
| vp_halt_req | output | NUM_VP | Level halt request per VP |

## Verification
The bench goes after the following corner cases, each of which a specific bug would reveal:
- Start writes carrying high garbage bits must not affect anything. A design with a wrong mask would show phantom running bits in the status read.
- A repeated start on a running VP must produce no pulse. A design without filtering would reset a live processor.
- A halt landing on a VP during its reset pulse must win. A design that filters only against the running vector would let that VP come up running.
- Status must read the same through both windows, and unmapped addresses must be inert. A bad decoder would either miss the alias or act on an unmapped write.
- Reset is asserted a second time mid-run. A design that launched the boot set from reset values instead of through the start path would show running bits before any pulse.

// File: rtl/vpc_pkg.sv
package vpc_pkg;

  // Register selected by a bus address, independent of window
  typedef enum logic [1:0] {
    REG_NONE = 2'd0,
    REG_RUN  = 2'd1,
    REG_STOP = 2'd2,
    REG_STAT = 2'd3
  } vpc_reg_e;

  localparam int NUM_WIN = 2;

endpackage

// File: rtl/vpc_addr_dec.sv
module vpc_addr_dec
  import vpc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] WIN0_BASE = 16'h2000,
  parameter logic [ADDR_W-1:0] WIN1_BASE = 16'h4000,
  parameter logic [ADDR_W-1:0] RUN_OFS   = 16'h0010,
  parameter logic [ADDR_W-1:0] STOP_OFS  = 16'h0018,
  parameter logic [ADDR_W-1:0] STAT_OFS  = 16'h0020
) (
  input  logic [ADDR_W-1:0] addr,
  output vpc_reg_e          sel
);

  localparam logic [ADDR_W-1:0] BASES [NUM_WIN] = '{WIN0_BASE, WIN1_BASE};

  logic [NUM_WIN-1:0] hit_run, hit_stop, hit_stat;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    localparam logic [ADDR_W-1:0] A_RUN  = BASES[w] + RUN_OFS;
    localparam logic [ADDR_W-1:0] A_STOP = BASES[w] + STOP_OFS;
    localparam logic [ADDR_W-1:0] A_STAT = BASES[w] + STAT_OFS;
    assign hit_run[w]  = (addr == A_RUN);
    assign hit_stop[w] = (addr == A_STOP);
    assign hit_stat[w] = (addr == A_STAT);
  end

  always_comb begin
    sel = REG_NONE;
    if (|hit_run)       sel = REG_RUN;
    else if (|hit_stop) sel = REG_STOP;
    else if (|hit_stat) sel = REG_STAT;
  end

endmodule

// File: rtl/vpc_vp_slice.sv
module vpc_vp_slice (
  input  logic clk,
  input  logic rst_n,
  input  logic start_cmd,
  input  logic stop_cmd,
  output logic rst_pulse,
  output logic running,
  output logic halt_req
);

  logic busy, start_ok, stop_hit;

  // A VP in its reset pulse counts as busy: no second start, and a stop cancels it
  assign busy     = running | rst_pulse;
  assign start_ok = start_cmd & ~busy & ~stop_cmd;
  assign stop_hit = stop_cmd & busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rst_pulse <= 1'b0;
      running   <= 1'b0;
      halt_req  <= 1'b1;
    end else begin
      rst_pulse <= start_ok;
      if (stop_hit)       running <= 1'b0;
      else if (rst_pulse) running <= 1'b1;
      if (stop_hit)      halt_req <= 1'b1;
      else if (start_ok) halt_req <= 1'b0;
    end
  end

endmodule

// File: rtl/vpc_runstop_ctrl.sv
module vpc_runstop_ctrl
  import vpc_pkg::*;
#(
  parameter int NUM_VP = 1,
  parameter logic [63:0] START_RUNNING = 64'h1,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 64,
  parameter logic [ADDR_W-1:0] CLUSTER_BASE = 16'h2000,
  parameter logic [ADDR_W-1:0] LOCAL_BASE   = 16'h4000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [NUM_VP-1:0] vp_reset_pulse,
  output logic [NUM_VP-1:0] vp_run_en,
  output logic [NUM_VP-1:0] vp_halt_req
);

  // Configuration checks
  if (NUM_VP < 1 || NUM_VP > DATA_W || NUM_VP > 64) begin : g_bad_count
    $error("vpc_runstop_ctrl: NUM_VP out of range");
  end
  if (NUM_VP < 64) begin : g_chk_boot
    if ((START_RUNNING >> NUM_VP) != 64'd0) begin : g_bad_boot
      $error("vpc_runstop_ctrl: START_RUNNING selects a VP beyond NUM_VP");
    end
  end

  vpc_reg_e sel;

  vpc_addr_dec #(
    .ADDR_W   (ADDR_W),
    .WIN0_BASE(CLUSTER_BASE),
    .WIN1_BASE(LOCAL_BASE)
  ) u_dec (
    .addr(bus_addr),
    .sel (sel)
  );

  // One-cycle boot strobe after reset release, launching the START_RUNNING set
  logic boot;
  always_ff @(posedge clk) begin
    if (!rst_n) boot <= 1'b1;
    else        boot <= 1'b0;
  end

  logic wr_run, wr_stop;
  assign wr_run  = bus_valid & bus_write & (sel == REG_RUN);
  assign wr_stop = bus_valid & bus_write & (sel == REG_STOP);

  // Only the low NUM_VP data bits take part; the rest are dropped here
  logic [NUM_VP-1:0] vp_bits, boot_set, start_vec, stop_vec;
  assign vp_bits   = bus_wdata[NUM_VP-1:0];
  assign boot_set  = START_RUNNING[NUM_VP-1:0];
  assign start_vec = (wr_run ? vp_bits : '0) | (boot ? boot_set : '0);
  assign stop_vec  = wr_stop ? vp_bits : '0;

  if (NUM_VP < DATA_W) begin : g_pad
    logic unused_hi;
    assign unused_hi = ^bus_wdata[DATA_W-1:NUM_VP];
  end

  for (genvar i = 0; i < NUM_VP; i++) begin : g_vp
    vpc_vp_slice u_slice (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_cmd(start_vec[i]),
      .stop_cmd (stop_vec[i]),
      .rst_pulse(vp_reset_pulse[i]),
      .running  (vp_run_en[i]),
      .halt_req (vp_halt_req[i])
    );
  end

  // Read response, one cycle after the request
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= bus_valid & ~bus_write;
      if (bus_valid && !bus_write && sel == REG_STAT)
        rsp_rdata <= DATA_W'(vp_run_en);
      else
        rsp_rdata <= '0;
    end
  end

endmodule

// File: rtl/vpc_runstop_chk.sv
module vpc_runstop_chk #(
  parameter int NUM_VP = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic              rsp_valid,
  input logic [NUM_VP-1:0] vp_reset_pulse,
  input logic [NUM_VP-1:0] vp_run_en,
  input logic [NUM_VP-1:0] vp_halt_req
);

  p_pulse_not_running_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (vp_reset_pulse & vp_run_en) == '0);

  p_rise_after_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((vp_run_en & ~$past(vp_run_en)) & ~$past(vp_reset_pulse)) == '0);

  p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (vp_reset_pulse & $past(vp_reset_pulse)) == '0);

  p_halt_on_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((~vp_run_en & $past(vp_run_en)) & ~vp_halt_req) == '0);

  p_halt_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((~vp_halt_req & $past(vp_halt_req)) & ~vp_reset_pulse) == '0);

  p_halt_excl_run_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (vp_halt_req & vp_run_en) == '0);

  p_rsp_after_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(bus_valid && !bus_write));

endmodule

bind vpc_runstop_ctrl vpc_runstop_chk #(.NUM_VP(NUM_VP)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bus_valid     (bus_valid),
  .bus_write     (bus_write),
  .rsp_valid     (rsp_valid),
  .vp_reset_pulse(vp_reset_pulse),
  .vp_run_en     (vp_run_en),
  .vp_halt_req   (vp_halt_req)
);

// File: tb/vpc_runstop_ctrl_tb_top.sv
module vpc_runstop_ctrl_tb_top;

  localparam int NV = 4;
  localparam logic [15:0] CL_RUN  = 16'h2010, CL_STOP = 16'h2018, CL_STAT = 16'h2020;
  localparam logic [15:0] LO_RUN  = 16'h4010, LO_STOP = 16'h4018, LO_STAT = 16'h4020;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [63:0] bus_wdata = '0;
  logic rsp_valid;
  logic [63:0] rsp_rdata;
  logic [NV-1:0] vp_reset_pulse, vp_run_en, vp_halt_req;

  always #10 clk = ~clk;  // 50 MHz

  vpc_runstop_ctrl #(.NUM_VP(NV), .START_RUNNING(64'h5)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .vp_reset_pulse(vp_reset_pulse),
    .vp_run_en(vp_run_en), .vp_halt_req(vp_halt_req)
  );

  int n_chk = 0, n_fail = 0, viol = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Called at a negedge; returns at the next negedge, one posedge later
  task automatic wr(input logic [15:0] a, input logic [63:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [63:0] d, output logic v);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    d = rsp_rdata; v = rsp_valid;
  endtask

  // R10 invariant monitor
  always @(negedge clk) if (rst_n && ((vp_run_en & vp_halt_req) != '0)) viol++;

  // Vector table: op (1 = read), address, data, expected status afterwards
  localparam int NVEC = 10;
  localparam logic        T_RD   [NVEC] = '{0, 0, 1, 0, 0, 0, 1, 0, 0, 1};
  localparam logic [15:0] T_ADDR [NVEC] = '{CL_RUN, LO_STOP, LO_STAT, CL_RUN, CL_STOP,
                                            16'h2028, 16'h2008, LO_RUN, CL_STOP, CL_STAT};
  localparam logic [63:0] T_DATA [NVEC] = '{64'h2, 64'h1, 64'h0, 64'hFFFF_FFFF_FFFF_FFF0,
                                            64'hF0, 64'hF, 64'h0, 64'hF, 64'hA, 64'h0};
  localparam logic [63:0] T_EXP  [NVEC] = '{64'h7, 64'h6, 64'h6, 64'h6, 64'h6,
                                            64'h6, 64'h0, 64'hF, 64'h5, 64'h5};
  // Entry tags: 0 R2/R3, 1 R4/R7, 2 R5/R7, 3 R1, 4 R1, 5 R6, 6 R6, 7 R7, 8 R4, 9 R5
  localparam int T_TAG [NVEC] = '{2, 4, 7, 1, 1, 6, 6, 7, 4, 5};

  initial begin
    logic [63:0] d;
    logic v;
    repeat (3) @(negedge clk);
    // R8: state while reset is held
    chk("R8 run_en in reset", 64'(vp_run_en), 64'h0);
    chk("R8 halt in reset", 64'(vp_halt_req), 64'hF);
    chk("R8 pulse in reset", 64'(vp_reset_pulse), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 boot pulse", 64'(vp_reset_pulse), 64'h5);
    chk("R8 run_en during boot pulse", 64'(vp_run_en), 64'h0);
    @(negedge clk);
    chk("R8 boot running", 64'(vp_run_en), 64'h5);

    for (int k = 0; k < NVEC; k++) begin
      if (T_RD[k]) begin
        rd(T_ADDR[k], d, v);
        chk($sformatf("R%0d vec%0d rsp_valid", T_TAG[k], k), 64'(v), 64'h1);
        chk($sformatf("R%0d vec%0d rdata", T_TAG[k], k), d, T_EXP[k]);
      end else begin
        wr(T_ADDR[k], T_DATA[k]);
        @(negedge clk);
        rd(CL_STAT, d, v);
        chk($sformatf("R%0d vec%0d status", T_TAG[k], k), d, T_EXP[k]);
      end
    end

    // R2: start of an already running VP yields no pulse
    wr(CL_RUN, 64'h1);
    chk("R2 no pulse on running VP", 64'(vp_reset_pulse), 64'h0);
    chk("R5 no response to write", 64'(rsp_valid), 64'h0);
    // R3: start sequence ordering
    wr(LO_RUN, 64'h2);
    chk("R3 pulse", 64'(vp_reset_pulse), 64'h2);
    chk("R3 halt dropped", 64'(vp_halt_req), 64'h8);
    chk("R3 not yet running", 64'(vp_run_en), 64'h5);
    @(negedge clk);
    chk("R3 running after pulse", 64'(vp_run_en), 64'h7);
    chk("R3 pulse ends", 64'(vp_reset_pulse), 64'h0);
    // R4: stop and held halt
    wr(LO_STOP, 64'h2);
    chk("R4 run_en falls", 64'(vp_run_en), 64'h5);
    chk("R4 halt rises", 64'(vp_halt_req), 64'hA);
    repeat (5) @(negedge clk);
    chk("R4 halt held", 64'(vp_halt_req), 64'hA);
    // R4: stop of a non-running VP changes nothing
    wr(CL_STOP, 64'h8);
    chk("R4 idle stop run_en", 64'(vp_run_en), 64'h5);
    chk("R4 idle stop halt", 64'(vp_halt_req), 64'hA);
    // R9: stop during reset pulse cancels the start
    wr(CL_RUN, 64'h2);
    wr(CL_STOP, 64'h2);
    chk("R9 pulse gone", 64'(vp_reset_pulse), 64'h0);
    chk("R9 halt set", 64'(vp_halt_req), 64'hA);
    @(negedge clk);
    chk("R9 never running", 64'(vp_run_en), 64'h5);
    // R8: second reset mid-run
    rst_n = 1'b0;
    @(negedge clk);
    chk("R8 re-reset run_en", 64'(vp_run_en), 64'h0);
    chk("R8 re-reset halt", 64'(vp_halt_req), 64'hF);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 re-boot pulse", 64'(vp_reset_pulse), 64'h5);
    @(negedge clk);
    chk("R8 re-boot running", 64'(vp_run_en), 64'h5);
    chk("R10 run and halt exclusive", 64'(viol), 64'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule